// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block watches the data beats that move across a NAND flash data bus and builds a 24-bit single-error-correcting Hamming code over one sector. For every byte it updates a pair of parity bits (one for "address bit clear", one for "address bit set") for each of the three bit-in-byte index bits and for each byte-address bit. This gives twelve even-side and twelve odd-side parities for a 512-byte sector. The code is not inverted, so a sector of zeros yields a zero code.

Software drives the block through four 32-bit registers. It sets the chip select to watch, the column width (8 or 16 bits) and the enable bit in the config register. It sets the sector length, counted in 16-bit words, in the size register. It clears the parities through the control register, streams one sector and then reads the result register or takes the packed three-byte code from a dedicated output. Only beats tagged with the configured chip select count, and the block stops counting at the end of the sector.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, all four registers read zero and `code_o` is zero.
- R2: Register map by `reg_addr_i`: 0 = control, 1 = size, 2 = config, 3 = result (read-only). Read data appears on `reg_rdata_o` one cycle after `reg_rd_i`. The size register stores bits 31:22 (word count minus one) and bits 3:0 (unit select). The config register stores bit 0 (enable), bits 3:1 (chip select) and bit 7 (16-bit column). The control register reads back bit 0 only, and bit 8 always reads zero.
- R3: Column parities: for k = 0,1,2, the even parity k is the XOR of all data bits whose bit index has bit k clear, and the odd parity k is the XOR of the bits whose index has bit k set.
- R4: Row parities: for byte-address bit j (0..8), the even parity 3+j is the XOR of all bits of bytes whose address has bit j clear, and the odd parity 3+j covers the bytes whose address has bit j set.
- R5: The result register holds the even parities 0..11 in bits 11:0 and the odd parities in bits 27:16, with all other bits zero.
- R6: `code_o[7:0]` = result[7:0], `code_o[15:8]` = result[23:16], `code_o[19:16]` = result[11:8], `code_o[23:20]` = result[27:24].
- R7: In 16-bit mode, each beat carries two bytes. The low byte sits at even address 2n and the high byte at 2n+1, where n is the beat index.
- R8: A beat whose chip-select tag differs from the config field, or any beat while enable is 0, leaves the result unchanged and does not advance the byte address.
- R9: With size field N, exactly 2(N+1) beats are accumulated in 8-bit mode and N+1 beats in 16-bit mode. Later beats are ignored.
- R10: Writing control with bit 8 set zeroes all parities and restarts the byte address at 0. A beat in the same cycle as this write is discarded.
- R11: When size bit 0 is clear, the result unit is inactive and beats are ignored.
- R12: A sector of all-zero bytes yields an all-zero result and code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| beat_valid_i | input | 1 | Data beat valid |
| beat_cs_i | input | 3 | Chip-select tag of the beat |
| beat_data_i | input | 16 | Beat data; low byte only in 8-bit mode |
| code_o | output | 24 | Packed three-byte code |

## Verification
A clearing write to the control register and a qualifying data beat can land on the same clock edge. The bench provokes this after part of a sector has streamed, by asserting the write strobe and the beat strobe on the same cycle. It judges the outcome by reading a zero result. It then checks that a fresh stream's parities match a model that places its first byte at address zero, which shows that both the parities and the address counter restarted and that the colliding beat left no trace.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_SIZE   = 2'd1,
    REG_CFG    = 2'd2,
    REG_RESULT = 2'd3
  } reg_sel_e;

  localparam int CLR_BIT  = 8;
  localparam int PTR_BIT  = 0;
  localparam int EN_BIT   = 0;
  localparam int CS_LSB   = 1;
  localparam int CS_W     = 3;
  localparam int WIDE_BIT = 7;
  localparam int SZ_LSB   = 22;
  localparam int SZ_W     = 10;
  localparam int SEL_W    = 4;
  localparam int ODD_LSB  = 16;
  localparam int COL_BITS = 3;

  typedef struct packed {
    logic            wide;
    logic [CS_W-1:0] cs;
    logic            en;
  } cfg_t;
endpackage

// File: rtl/nand_ecc_regs.sv
module nand_ecc_regs
  import nand_ecc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [1:0]            addr,
  input  logic [31:0]           wdata,
  input  logic [31:0]           res_word,
  output logic [31:0]           rdata,
  output cfg_t                  cfg,
  output logic [SZ_W-1:0]       sz_words,
  output logic [SEL_W-1:0]      unit_sel,
  output logic                  clr_pulse
);
  logic ptr_q;

  assign clr_pulse = wr_en && (reg_sel_e'(addr) == REG_CTRL) && wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= 1'b0;
      cfg      <= '0;
      sz_words <= '0;
      unit_sel <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(addr))
        REG_CTRL: ptr_q <= wdata[PTR_BIT];
        REG_SIZE: begin
          sz_words <= wdata[SZ_LSB +: SZ_W];
          unit_sel <= wdata[SEL_W-1:0];
        end
        REG_CFG: begin
          cfg.en   <= wdata[EN_BIT];
          cfg.cs   <= wdata[CS_LSB +: CS_W];
          cfg.wide <= wdata[WIDE_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (reg_sel_e'(addr))
        REG_CTRL:   rdata <= {31'b0, ptr_q};
        REG_SIZE:   rdata <= {sz_words, {(32-SZ_W-SEL_W){1'b0}}, unit_sel};
        REG_CFG:    rdata <= {24'b0, cfg.wide, 3'b0, cfg.cs, cfg.en};
        default:    rdata <= res_word;
      endcase
    end
  end
endmodule

// File: rtl/nand_ecc_gate.sv
module nand_ecc_gate #(
  parameter int ROW_BITS = 9,
  parameter int SZ_W     = 10,
  parameter int CS_W     = 3,
  localparam int CNT_W   = SZ_W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                en,
  input  logic                wide,
  input  logic                sel_active,
  input  logic [CS_W-1:0]     cs_cfg,
  input  logic [SZ_W-1:0]     sz_words,
  input  logic                beat_valid,
  input  logic [CS_W-1:0]     beat_cs,
  output logic                take,
  output logic [ROW_BITS-1:0] base_addr,
  output logic [CNT_W-1:0]    cnt_q,
  output logic [CNT_W-1:0]    limit
);
  logic [CNT_W-1:0] words_p1;

  assign words_p1 = {2'b00, sz_words} + CNT_W'(1);
  assign limit    = wide ? words_p1 : {words_p1[CNT_W-2:0], 1'b0};

  assign take = beat_valid && en && sel_active && (beat_cs == cs_cfg)
                && (cnt_q < limit) && !clr;

  assign base_addr = wide ? {cnt_q[ROW_BITS-2:0], 1'b0} : cnt_q[ROW_BITS-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc #(
  parameter int ROW_BITS = 9,
  parameter int LANES    = 2,
  localparam int NPAR    = 3 + ROW_BITS,
  localparam int DW      = 8 * LANES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                take,
  input  logic                wide,
  input  logic [ROW_BITS-1:0] base_addr,
  input  logic [DW-1:0]       data,
  output logic [NPAR-1:0]     even_q,
  output logic [NPAR-1:0]     odd_q
);
  logic [LANES-1:0][NPAR-1:0] lane_e;
  logic [LANES-1:0][NPAR-1:0] lane_o;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0]          d;
    logic [ROW_BITS-1:0] a;
    logic                on;
    logic                bpar;
    logic [NPAR-1:0]     pe;
    logic [NPAR-1:0]     po;

    assign d    = data[8*l +: 8];
    assign a    = base_addr | ROW_BITS'(l);
    assign on   = (l == 0) || wide;
    assign bpar = ^d;

    always_comb begin
      pe = '0;
      po = '0;
      if (on) begin
        for (int k = 0; k < 3; k++) begin
          for (int b = 0; b < 8; b++) begin
            if (((b >> k) & 1) == 1) po[k] = po[k] ^ d[b];
            else                     pe[k] = pe[k] ^ d[b];
          end
        end
        for (int j = 0; j < ROW_BITS; j++) begin
          if (a[j]) po[3+j] = bpar;
          else      pe[3+j] = bpar;
        end
      end
    end

    assign lane_e[l] = pe;
    assign lane_o[l] = po;
  end

  logic [NPAR-1:0] sum_e, sum_o;
  always_comb begin
    sum_e = '0;
    sum_o = '0;
    for (int l = 0; l < LANES; l++) begin
      sum_e = sum_e ^ lane_e[l];
      sum_o = sum_o ^ lane_o[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (take) begin
      even_q <= even_q ^ sum_e;
      odd_q  <= odd_q ^ sum_o;
    end
  end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int ROW_BITS = 9,
  localparam int NPAR    = COL_BITS + ROW_BITS,
  localparam int CNT_W   = SZ_W + 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        beat_valid_i,
  input  logic [2:0]  beat_cs_i,
  input  logic [15:0] beat_data_i,
  output logic [23:0] code_o
);
  cfg_t                cfg_q;
  logic [SZ_W-1:0]     sz_words;
  logic [SEL_W-1:0]    unit_sel;
  logic                clr_pulse;
  logic                sel_active;
  logic                cfg_en;
  logic                beat_take;
  logic [ROW_BITS-1:0] base_addr;
  logic [CNT_W-1:0]    beat_cnt;
  logic [CNT_W-1:0]    beat_limit;
  logic [NPAR-1:0]     par_even;
  logic [NPAR-1:0]     par_odd;
  logic [31:0]         res_word;

  assign sel_active = unit_sel[0];
  assign cfg_en     = cfg_q.en;
  assign res_word   = {{(ODD_LSB-NPAR){1'b0}}, par_odd, {(ODD_LSB-NPAR){1'b0}}, par_even};
  assign code_o     = {res_word[27:24], res_word[11:8], res_word[23:16], res_word[7:0]};

  nand_ecc_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_i),
    .rd_en    (reg_rd_i),
    .addr     (reg_addr_i),
    .wdata    (reg_wdata_i),
    .res_word (res_word),
    .rdata    (reg_rdata_o),
    .cfg      (cfg_q),
    .sz_words (sz_words),
    .unit_sel (unit_sel),
    .clr_pulse(clr_pulse)
  );

  nand_ecc_gate #(.ROW_BITS(ROW_BITS), .SZ_W(SZ_W), .CS_W(CS_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_pulse),
    .en        (cfg_q.en),
    .wide      (cfg_q.wide),
    .sel_active(sel_active),
    .cs_cfg    (cfg_q.cs),
    .sz_words  (sz_words),
    .beat_valid(beat_valid_i),
    .beat_cs   (beat_cs_i),
    .take      (beat_take),
    .base_addr (base_addr),
    .cnt_q     (beat_cnt),
    .limit     (beat_limit)
  );

  nand_ecc_acc #(.ROW_BITS(ROW_BITS), .LANES(2)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_pulse),
    .take     (beat_take),
    .wide     (cfg_q.wide),
    .base_addr(base_addr),
    .data     (beat_data_i),
    .even_q   (par_even),
    .odd_q    (par_odd)
  );
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
  parameter int NPAR  = 12,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             beat_valid,
  input logic             take,
  input logic             clr,
  input logic             cfg_en,
  input logic             sel_active,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] limit,
  input logic [NPAR-1:0]  even,
  input logic [NPAR-1:0]  odd
);
  // R8: without an accepted beat or a clear, parities keep their value
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!take && !clr) |=> ($stable(even) && $stable(odd)));

  // R8: an accepted beat needs a valid strobe and the enable bit
  p_take_r8: assert property (@(posedge clk) disable iff (rst)
    take |-> (beat_valid && cfg_en));

  // R10: a clear leaves all parities zero on the next cycle
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (even == '0 && odd == '0));

  // R9: no beat is accepted once the sector count is reached
  p_limit_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt >= limit) |-> !take);

  // R11: an inactive result unit accepts nothing
  p_sel_r11: assert property (@(posedge clk) disable iff (rst)
    !sel_active |-> !take);
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.NPAR(NPAR), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .beat_valid(beat_valid_i),
  .take      (beat_take),
  .clr       (clr_pulse),
  .cfg_en    (cfg_en),
  .sel_active(sel_active),
  .cnt       (beat_cnt),
  .limit     (beat_limit),
  .even      (par_even),
  .odd       (par_odd)
);

// File: tb/nand_ecc_gen_test.sv
module nand_ecc_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        beat_valid = 1'b0;
  logic [2:0]  beat_cs = '0;
  logic [15:0] beat_data = '0;
  logic [23:0] code;

  int total = 0;
  int bad = 0;
  logic [7:0] mem [0:511];

  always #2 clk = ~clk;

  nand_ecc_gen uut (
    .clk(clk), .rst(rst),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .beat_valid_i(beat_valid), .beat_cs_i(beat_cs), .beat_data_i(beat_data),
    .code_o(code)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent parity model over mem[0..n-1]
  function automatic logic [31:0] model(input int n);
    logic [11:0] e = '0;
    logic [11:0] o = '0;
    for (int i = 0; i < n; i++) begin
      logic bp = ^mem[i];
      for (int k = 0; k < 3; k++)
        for (int b = 0; b < 8; b++)
          if (((b >> k) & 1) == 1) o[k] = o[k] ^ mem[i][b];
          else                     e[k] = e[k] ^ mem[i][b];
      for (int j = 0; j < 9; j++)
        if (((i >> j) & 1) == 1) o[3+j] = o[3+j] ^ bp;
        else                     e[3+j] = e[3+j] ^ bp;
    end
    return {4'b0, o, 4'b0, e};
  endfunction

  function automatic logic [31:0] pack(input logic [31:0] r);
    return {8'b0, r[27:24], r[11:8], r[23:16], r[7:0]};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic stream(input int beats, input logic [2:0] cs, input bit wide);
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      beat_valid = 1'b1; beat_cs = cs;
      beat_data = wide ? {mem[2*i+1], mem[2*i]} : {8'h00, mem[i]};
    end
    @(negedge clk);
    beat_valid = 1'b0;
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) mem[i] = 8'((i * 37 + seed) ^ (i >> 2));
  endtask

  task automatic setup(input int words_m1, input logic [3:0] sel, input logic [31:0] cfgv);
    wr(2'd1, (32'(words_m1) << 22) | 32'(sel));
    wr(2'd2, cfgv);
    wr(2'd0, 32'h101);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reg reset", v, 32'h0);
    end
    check("R1 code reset", {8'b0, code}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(2'd1, (32'd7 << 22) | 32'h9);
    rd(2'd1, v); check("R2 size readback", v, (32'd7 << 22) | 32'h9);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R2 cfg readback", v, 32'h8F);
    wr(2'd0, 32'h101);
    rd(2'd0, v); check("R2 ctrl readback", v, 32'h1);
  endtask

  task automatic t_bytes;
    logic [31:0] v;
    setup(7, 4'h1, 32'h05);
    fill(16, 11);
    stream(16, 3'd2, 1'b0);
    rd(2'd3, v);
    check("R3 R4 R5 byte sector", v, model(16));
    check("R6 packed code", {8'b0, code}, pack(model(16)));
  endtask

  task automatic t_zero;
    logic [31:0] v;
    setup(7, 4'h1, 32'h05);
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    stream(16, 3'd2, 1'b0);
    rd(2'd3, v);
    check("R12 zero result", v, 32'h0);
    check("R12 zero code", {8'b0, code}, 32'h0);
  endtask

  task automatic t_full;
    logic [31:0] v, first;
    setup(255, 4'h1, 32'h05);
    fill(512, 3);
    stream(512, 3'd2, 1'b0);
    rd(2'd3, v);
    first = v;
    check("R4 full sector", v, model(512));
    wr(2'd0, 32'h101);
    mem[300] = mem[300] ^ 8'h20;
    stream(512, 3'd2, 1'b0);
    rd(2'd3, v);
    check("R4 flipped bit", v, model(512));
    check("R4 flip changes code", 32'(v != first), 32'h1);
  endtask

  task automatic t_wide;
    logic [31:0] v;
    setup(7, 4'h1, 32'h85);
    fill(16, 90);
    stream(8, 3'd2, 1'b1);
    rd(2'd3, v);
    check("R7 wide sector", v, model(16));
  endtask

  task automatic t_ignore;
    logic [31:0] v;
    setup(7, 4'h1, 32'h05);
    fill(8, 200);
    stream(8, 3'd5, 1'b0);
    rd(2'd3, v); check("R8 cs mismatch", v, 32'h0);
    wr(2'd2, 32'h04);
    stream(8, 3'd2, 1'b0);
    rd(2'd3, v); check("R8 disabled", v, 32'h0);
    wr(2'd2, 32'h05);
    stream(8, 3'd2, 1'b0);
    rd(2'd3, v); check("R8 address not advanced", v, model(8));
  endtask

  task automatic t_limit;
    logic [31:0] v;
    setup(1, 4'h1, 32'h05);
    fill(6, 77);
    stream(6, 3'd2, 1'b0);
    rd(2'd3, v); check("R9 byte limit", v, model(4));
    setup(1, 4'h1, 32'h85);
    fill(6, 55);
    stream(3, 3'd2, 1'b1);
    rd(2'd3, v); check("R9 word limit", v, model(4));
  endtask

  task automatic t_collide;
    logic [31:0] v;
    setup(7, 4'h1, 32'h05);
    fill(3, 19);
    stream(3, 3'd2, 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h100;
    beat_valid = 1'b1; beat_cs = 3'd2; beat_data = 16'h00A5;
    @(negedge clk);
    reg_wr = 1'b0; beat_valid = 1'b0;
    rd(2'd3, v); check("R10 clear with beat", v, 32'h0);
    fill(4, 140);
    stream(4, 3'd2, 1'b0);
    rd(2'd3, v); check("R10 restart at zero", v, model(4));
  endtask

  task automatic t_sel;
    logic [31:0] v;
    setup(7, 4'hE, 32'h05);
    fill(8, 61);
    stream(8, 3'd2, 1'b0);
    rd(2'd3, v); check("R11 unit inactive", v, 32'h0);
  endtask

  initial begin
    #(4 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_bytes();
    t_zero();
    t_full();
    t_wide();
    t_ignore();
    t_limit();
    t_collide();
    t_sel();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule